// File: doc/BRIEF.md
# Dual-Slot Card Status Interrupt Unit

This unit watches the status pins of two removable-card slots and turns their activity into an interrupt. Each slot has eight pins: two voltage-sense pins, write-protect, two card-detect pins, two battery-voltage pins and ready. The pins are synchronized, shown in a read-only pin word, and compared cycle to cycle. Every transition sets a sticky bit in a change word. Software clears a bit by writing a one to it.

The pin, change and enable words are 32 bits wide and shared by the two slots. Slot A owns the upper 16-bit lane and slot B the lower lane, with the same layout, so the same bit of slot B sits 16 positions below it. The ready pin feeds four extra flags: low level, high level, rising edge and falling edge. A level flag cannot be cleared for good while its level holds. A card-detect event counts only when both detect pins agree once the edge has passed.

A single interrupt is raised when any change bit is set together with its enable bit. Each slot also has a small control word. It drives an active-high card reset pin and an active-low buffer enable pin.

Top module: `card_status_irq_unit`

## Requirements
- R1: Address 0 reads the pin word. Slot A pins sit at bits 31..24 in the order VS1 (31), VS2, WP, CD2, CD1, BVD2, BVD1, RDY (24), and slot B pins at bits 15..8 in the same order. All other bits read 0. A pin change is visible there after two rising clock edges.
- R2: Address 1 is the change word. For the VS1, VS2, WP, BVD2, BVD1 and RDY pins, any rising or falling transition sets the change bit at the same position as the pin. The bit is readable after three rising edges.
- R3: The two card-detect change bits (27 and 28 for slot A) set together, and only when a detect pin transitions and both detect pins are equal afterwards. While the detect pins disagree, neither bit sets.
- R4: The ready rising-edge flag is bit 21 for slot A and bit 5 for slot B. The falling-edge flag is bit 20 for slot A and bit 4 for slot B.
- R5: The ready low-level flag (bit 23 for A, bit 7 for B) is set on every cycle that ready reads low. The high-level flag (bit 22 for A, bit 6 for B) is set on every cycle that ready reads high. Clearing a level flag while its condition holds leaves it set.
- R6: Writing a one to a change bit clears it, and writing a zero leaves it unchanged. A set condition in the same cycle wins over the clear. Bits 19..16 and 3..0 always read 0. Writes to the pin word have no effect.
- R7: Address 2 is a read/write enable word. The irq_o output goes high one rising edge after a change bit is set under a set enable bit, and goes low one edge after no such pair remains.
- R8: Address 3 is slot A control and address 4 is slot B control. Bit 6 drives the card reset pin (active high) and bit 7 drives the buffer enable pin (active low). Other bits read 0, and writing one slot's word leaves the other unchanged. Addresses 5 to 7 read 0.
- R9: After reset, the change and enable words are 0, irq_o is low, both control words read 0x80, and the pin word reads 0. No change bit comes from the synchronizer filling after reset: only the ready level flags appear.
- R10: The slot B lane behaves like the slot A lane, 16 bits lower, and activity in one slot sets no bit in the other slot's lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_sel_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | Write when high, read when low |
| bus_addr_i | input | 3 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from address |
| pins_a_i | input | 8 | Slot A pins {VS1,VS2,WP,CD2,CD1,BVD2,BVD1,RDY} |
| pins_b_i | input | 8 | Slot B pins, same order |
| irq_o | output | 1 | Registered status interrupt |
| card_rst_a_o | output | 1 | Slot A card reset, active high |
| card_oe_n_a_o | output | 1 | Slot A buffer enable, active low |
| card_rst_b_o | output | 1 | Slot B card reset, active high |
| card_oe_n_b_o | output | 1 | Slot B buffer enable, active low |

## Verification
A pin change reaches the pin word after two rising edges and the change word after three, and irq_o follows one edge after that. Control and enable writes take effect at the edge that ends the write. The bench changes inputs on the falling edge and counts falling edges before each read, so every check lands in the exact cycle the result is due. Where a result must not yet be there, it also checks the cycle before. Level flags are checked both right after a clear while the level holds and after the level changes.

// File: rtl/cstat_pkg.sv
package cstat_pkg;
  localparam int SLOTS  = 2;
  localparam int LANE_W = 16;
  localparam int PIN_W  = 8;
  localparam int REG_W  = SLOTS * LANE_W;

  // pin positions inside one slot's pin vector
  localparam int P_RDY  = 0;
  localparam int P_BVD1 = 1;
  localparam int P_BVD2 = 2;
  localparam int P_CD1  = 3;
  localparam int P_CD2  = 4;
  localparam int P_WP   = 5;
  localparam int P_VS2  = 6;
  localparam int P_VS1  = 7;

  // lane positions: pins occupy the top PIN_W bits of a lane
  localparam int PIN_BASE = LANE_W - PIN_W;
  localparam int L_CD1    = PIN_BASE + P_CD1;
  localparam int L_CD2    = PIN_BASE + P_CD2;
  localparam int L_RLOW   = PIN_BASE - 1;
  localparam int L_RHIGH  = PIN_BASE - 2;
  localparam int L_RRISE  = PIN_BASE - 3;
  localparam int L_RFALL  = PIN_BASE - 4;
endpackage

// File: rtl/cstat_sync.sv
module cstat_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < STAGES; k++) stage_q[k] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int k = 1; k < STAGES; k++) stage_q[k] <= stage_q[k-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/cstat_lane.sv
module cstat_lane
  import cstat_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              armed_i,
  input  logic [PIN_W-1:0]  pins_i,
  input  logic [LANE_W-1:0] clr_i,
  output logic [LANE_W-1:0] chg_o
);
  logic [PIN_W-1:0]  prev_q;
  logic [LANE_W-1:0] chg_q, chg_d, set_v;
  logic [PIN_W-1:0]  toggled;
  logic              cd_agree, cd_evt, chg_en;

  always_comb begin
    toggled  = pins_i ^ prev_q;
    cd_agree = (pins_i[P_CD1] == pins_i[P_CD2]);
    cd_evt   = (toggled[P_CD1] | toggled[P_CD2]) & cd_agree;
    set_v    = '0;
    if (armed_i) begin
      set_v[LANE_W-1 -: PIN_W] = toggled;
      set_v[L_CD1]   = cd_evt;
      set_v[L_CD2]   = cd_evt;
      set_v[L_RLOW]  = ~pins_i[P_RDY];
      set_v[L_RHIGH] =  pins_i[P_RDY];
      set_v[L_RRISE] =  pins_i[P_RDY] & ~prev_q[P_RDY];
      set_v[L_RFALL] = ~pins_i[P_RDY] &  prev_q[P_RDY];
    end
    chg_d  = (chg_q & ~clr_i) | set_v;
    chg_en = (|set_v) | (|clr_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= pins_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     chg_q <= '0;
    else if (chg_en) chg_q <= chg_d;
  end

  assign chg_o = chg_q;

  // R3: disagreeing detect pins never raise the detect change bits
  a_r3_cd_disagree_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pins_i[P_CD1] != pins_i[P_CD2]) |=> !$rose(chg_q[L_CD1]) && !$rose(chg_q[L_CD2]));

  // R5: low ready level keeps its flag set whatever is written
  a_r5_low_level_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_i && !pins_i[P_RDY]) |=> chg_q[L_RLOW]);

  // R6: a one written with no competing set clears the bit
  a_r6_w1c_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i & ~set_v) != '0) |=> ((chg_q & $past(clr_i & ~set_v)) == '0));
endmodule

// File: rtl/cstat_ctrl.sv
module cstat_ctrl #(
  parameter logic [1:0] RST_VAL = 2'b10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [1:0] wbits_i,
  output logic [1:0] bits_o
);
  logic [1:0] bits_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   bits_q <= RST_VAL;
    else if (we_i) bits_q <= wbits_i;
  end

  assign bits_o = bits_q;

  // R8: control bits move only on a write to their own word
  a_r8_ctrl_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(bits_q));
endmodule

// File: rtl/card_status_irq_unit.sv
module card_status_irq_unit
  import cstat_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  input  logic [7:0]        pins_a_i,
  input  logic [7:0]        pins_b_i,
  output logic              irq_o,
  output logic              card_rst_a_o,
  output logic              card_oe_n_a_o,
  output logic              card_rst_b_o,
  output logic              card_oe_n_b_o
);
  localparam logic [ADDR_W-1:0] ADR_PIN = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADR_CHG = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ADR_EN  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] ADR_CTL = ADDR_W'(3);
  localparam int ARM_W   = SYNC_STAGES + 1;
  localparam int OE_BIT  = 7;
  localparam int RST_BIT = 6;

  logic [PIN_W-1:0] pins_raw  [SLOTS];
  logic [PIN_W-1:0] pins_sync [SLOTS];
  logic [1:0]       ctl_bits  [SLOTS];
  logic [REG_W-1:0] pin_word, chg_word, clr_word;
  logic [REG_W-1:0] en_q;
  logic [ARM_W-1:0] arm_q;
  logic             irq_q, irq_d;
  logic             wr, rd, en_we;

  assign pins_raw[0] = pins_a_i;
  assign pins_raw[1] = pins_b_i;

  assign wr       = bus_sel_i & bus_we_i;
  assign rd       = bus_sel_i & ~bus_we_i;
  assign en_we    = wr && (bus_addr_i == ADR_EN);
  assign clr_word = (wr && (bus_addr_i == ADR_CHG)) ? bus_wdata_i : '0;

  // arming: change detection starts once the synchronizer and history hold real pins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) arm_q <= '0;
    else         arm_q <= {arm_q[ARM_W-2:0], 1'b1};
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    localparam int TOP = REG_W - 1 - s * LANE_W;
    localparam logic [ADDR_W-1:0] MY_ADR = ADR_CTL + ADDR_W'(s);

    cstat_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) i_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (pins_raw[s]),
      .q_o    (pins_sync[s])
    );

    cstat_lane i_lane (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .armed_i (arm_q[ARM_W-1]),
      .pins_i  (pins_sync[s]),
      .clr_i   (clr_word[TOP -: LANE_W]),
      .chg_o   (chg_word[TOP -: LANE_W])
    );

    cstat_ctrl #(.RST_VAL(2'b10)) i_ctrl (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (wr && (bus_addr_i == MY_ADR)),
      .wbits_i (bus_wdata_i[OE_BIT:RST_BIT]),
      .bits_o  (ctl_bits[s])
    );

    assign pin_word[TOP -: LANE_W] = {pins_sync[s], {PIN_BASE{1'b0}}};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    en_q <= '0;
    else if (en_we) en_q <= bus_wdata_i;
  end

  assign irq_d = |(chg_word & en_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= irq_d;
  end

  always_comb begin
    bus_rdata_o = '0;
    if (rd) begin
      case (bus_addr_i)
        ADR_PIN:           bus_rdata_o = pin_word;
        ADR_CHG:           bus_rdata_o = chg_word;
        ADR_EN:            bus_rdata_o = en_q;
        ADR_CTL:           bus_rdata_o = {24'b0, ctl_bits[0], 6'b0};
        ADR_CTL + ADDR_W'(1): bus_rdata_o = {24'b0, ctl_bits[1], 6'b0};
        default:           bus_rdata_o = '0;
      endcase
    end
  end

  assign irq_o         = irq_q;
  assign card_rst_a_o  = ctl_bits[0][0];
  assign card_oe_n_a_o = ctl_bits[0][1];
  assign card_rst_b_o  = ctl_bits[1][0];
  assign card_oe_n_b_o = ctl_bits[1][1];

  // R7: an enabled pending change raises the interrupt on the next edge
  a_r7_irq_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((chg_word & en_q) != '0) |=> irq_o);

  // R7: with nothing enabled and pending the interrupt drops on the next edge
  a_r7_irq_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((chg_word & en_q) == '0) |=> !irq_o);
endmodule

// File: tb/test_card_status_irq_unit.sv
module test_card_status_irq_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sel, we;
  logic [2:0]  addr;
  logic [31:0] wdata, rdata;
  logic [7:0]  pa, pb;
  logic        irq, rst_a, oen_a, rst_b, oen_b;
  int          n_run = 0, n_fail = 0;
  logic [31:0] v;

  always #4 clk = ~clk;

  card_status_irq_unit i_card_status_irq_unit (
    .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .pins_a_i(pa), .pins_b_i(pb), .irq_o(irq),
    .card_rst_a_o(rst_a), .card_oe_n_a_o(oen_a),
    .card_rst_b_o(rst_b), .card_oe_n_b_o(oen_b)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    sel = 1'b1; we = 1'b0; addr = a; #1;
    d = rdata; sel = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; we = 1'b0; wdata = '0;
  endtask

  task automatic t_reset;
    rd(3'd1, v); chk("R9 change after reset", v, 32'h0);
    rd(3'd2, v); chk("R9 enable after reset", v, 32'h0);
    rd(3'd3, v); chk("R9 ctrl A after reset", v, 32'h80);
    rd(3'd4, v); chk("R9 ctrl B after reset", v, 32'h80);
    rd(3'd0, v); chk("R9 pin word after reset", v, 32'h0);
    chk("R9 irq after reset", {31'b0, irq}, 32'h0);
    chk("R9 pin outputs after reset", {28'b0, rst_a, oen_a, rst_b, oen_b}, 32'h5);
    tick(8);
    rd(3'd0, v); chk("R1 pin word layout", v, 32'hDF009F00);
    rd(3'd1, v); chk("R9 only level flags after arming", v, 32'h00400040);
  endtask

  task automatic t_pin_timing;
    wr(3'd1, 32'hFFFFFFFF);
    pa = 8'hFF; tick(1);
    rd(3'd0, v); chk("R1 pin word not yet updated", v, 32'hDF009F00);
    tick(1);
    rd(3'd0, v); chk("R1 pin word after two edges", v, 32'hFF009F00);
    rd(3'd1, v); chk("R2 WP bit not yet set", v, 32'h00400040);
    tick(1);
    rd(3'd1, v); chk("R2 WP rising sets bit 29", v, 32'h20400040);
    wr(3'd1, 32'hFFFFFFFF);
    pa = 8'hDF; tick(3);
    rd(3'd1, v); chk("R2 WP falling sets bit 29", v, 32'h20400040);
    wr(3'd1, 32'hFFFFFFFF);
    pb = 8'hDF; tick(3);
    rd(3'd1, v); chk("R10 slot B VS2 sets bit 14 only", v, 32'h00404040);
    pb = 8'h9F; tick(3);
    wr(3'd1, 32'hFFFFFFFF);
  endtask

  task automatic t_card_detect;
    pa = 8'hD7; tick(6);
    rd(3'd1, v); chk("R3 disagreeing detect pins quiet", v, 32'h00400040);
    wr(3'd2, 32'h08000000);
    pa = 8'hC7; tick(3);
    rd(3'd1, v); chk("R3 agreeing detect sets bits 28 and 27", v, 32'h18400040);
    chk("R7 irq not yet raised", {31'b0, irq}, 32'h0);
    tick(1);
    chk("R7 irq one edge after change", {31'b0, irq}, 32'h1);
    wr(3'd1, 32'h18000000);
    rd(3'd1, v); chk("R6 detect bits cleared", v, 32'h00400040);
    chk("R7 irq still high at clear edge", {31'b0, irq}, 32'h1);
    tick(1);
    chk("R7 irq low one edge after clear", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_w1c;
    pa = 8'hC5; tick(3);
    rd(3'd1, v); chk("R2 BVD1 toggle sets bit 25", v, 32'h02400040);
    wr(3'd1, 32'h0);
    rd(3'd1, v); chk("R6 zero write leaves change word", v, 32'h02400040);
    wr(3'd0, 32'hFFFFFFFF);
    rd(3'd0, v); chk("R6 pin word ignores writes", v, 32'hC5009F00);
    wr(3'd1, 32'h000F000F);
    rd(3'd1, v); chk("R6 reserved bits read zero", v, 32'h02400040);
    wr(3'd1, 32'h02000000);
    rd(3'd1, v); chk("R6 one write clears bit 25", v, 32'h00400040);
  endtask

  task automatic t_ready;
    pb = 8'h9E; tick(3);
    rd(3'd1, v); chk("R4 slot B ready fall flags", v & 32'h1F0, 32'h1D0);
    wr(3'd1, 32'h00000080);
    rd(3'd1, v); chk("R5 low level flag survives clear", v & 32'h80, 32'h80);
    wr(3'd1, 32'h000001F0);
    rd(3'd1, v); chk("R5 only low level remains", v & 32'h1F0, 32'h080);
    pb = 8'h9F; tick(3);
    rd(3'd1, v); chk("R4 slot B ready rise flags", v & 32'h1F0, 32'h1E0);
    chk("R10 slot A edge flags untouched", v & 32'h01300000, 32'h0);
    wr(3'd1, 32'h000001F0);
    rd(3'd1, v); chk("R5 high level remains after clear", v & 32'h1F0, 32'h040);
    pa = 8'hC4; tick(3);
    rd(3'd1, v); chk("R4 slot A ready fall flags", v & 32'h01F00000, 32'h01D00000);
    pa = 8'hC5; tick(3);
    wr(3'd1, 32'hFFFFFFFF);
  endtask

  task automatic t_enable;
    wr(3'd2, 32'hA5A5A5A5);
    rd(3'd2, v); chk("R7 enable readback", v, 32'hA5A5A5A5);
    wr(3'd2, 32'h0); tick(1);
    chk("R7 irq low with no enables", {31'b0, irq}, 32'h0);
    wr(3'd2, 32'h00000040);
    chk("R7 irq waits one edge after enable", {31'b0, irq}, 32'h0);
    tick(1);
    chk("R7 irq from enabled level flag", {31'b0, irq}, 32'h1);
    wr(3'd2, 32'h0); tick(1);
    chk("R7 irq drops when disabled", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_ctrl;
    wr(3'd3, 32'h00000040);
    chk("R8 slot A reset high, buffers on", {30'b0, rst_a, oen_a}, 32'h2);
    chk("R8 slot B pins unchanged", {30'b0, rst_b, oen_b}, 32'h1);
    rd(3'd3, v); chk("R8 ctrl A readback", v, 32'h40);
    wr(3'd4, 32'hFFFFFFFF);
    rd(3'd4, v); chk("R8 ctrl B keeps only bits 7:6", v, 32'hC0);
    chk("R8 slot B pins follow write", {30'b0, rst_b, oen_b}, 32'h3);
    rd(3'd3, v); chk("R8 ctrl A untouched by B write", v, 32'h40);
    rd(3'd5, v); chk("R8 unmapped address 5", v, 32'h0);
    rd(3'd7, v); chk("R8 unmapped address 7", v, 32'h0);
  endtask

  initial begin
    #(8 * 200000);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sel = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    pa = 8'hDF; pb = 8'h9F;
    tick(3);
    rst_n = 1'b1;
    t_reset();
    t_pin_timing();
    t_card_detect();
    t_w1c();
    t_ready();
    t_enable();
    t_ctrl();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule